// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction into every control line a single-cycle datapath needs. It decodes five register-to-register operations (add, subtract, and, or, set-on-less-than), word load, word store, branch-if-equal, plain jump and jump-and-link. It also produces the four-bit operation code that steers the ALU.

Beyond the control lines, the block resolves the two selects that jump-and-link extends. The first picks the destination register number: rt, rd, or the fixed link register. The second picks the write-back source: ALU result, memory data, or the incremented PC. It also builds the jump target from the incremented PC and the 26-bit instruction index. The block is purely combinational, so all outputs follow the inputs within the same cycle.

Top module: `instr_ctl_decoder`

## Requirements
- R1: Opcode 000000 with a recognised funct drives reg_dst=1, reg_write=1, alu_op=10 and every other control line to 0.
- R2: Opcode 100011 (load) drives alu_src, mem_to_reg, reg_write and mem_read to 1, alu_op=00, and reg_dst, mem_write, branch, jump and link to 0.
- R3: Opcode 101011 (store) drives alu_src and mem_write to 1, alu_op=00, and every other control line to 0.
- R4: Opcode 000100 (branch-if-equal) drives branch to 1, alu_op=01, and every other control line to 0.
- R5: Opcode 000010 (jump) drives jump to 1 and every other control line, including alu_op, to 0.
- R6: Opcode 000011 (jump-and-link) drives reg_write, jump and link to 1, alu_op=00, and every other control line to 0.
- R7: alu_op=00 gives alu_ctl=0010 (add) and alu_op=01 gives alu_ctl=0110 (subtract), whatever the funct value.
- R8: With alu_op=10, funct 100000 gives alu_ctl 0010, 100010 gives 0110, 100100 gives 0000, 100101 gives 0001, and 101010 gives 0111.
- R9: wr_reg equals 31 when link is 1, otherwise rd when reg_dst is 1, otherwise rt.
- R10: wb_sel is 10 (PC+4) when link is 1, otherwise 01 (memory) when mem_to_reg is 1, otherwise 00 (ALU).
- R11: jump_target equals bits 31:28 of pc_plus4, then the 26-bit instruction index, then two zero bits.
- R12: Any other opcode, or opcode 000000 with any other funct, drives every control line to 0. This makes reg_write, mem_write, branch and jump all 0, and alu_ctl is 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Instruction function field |
| rt_i | input | 5 | rt register number |
| rd_i | input | 5 | rd register number |
| pc_plus4_i | input | 32 | Address of the next sequential instruction |
| instr_index_i | input | 26 | Instruction bits 25:0 |
| reg_dst_o | output | 1 | Destination comes from rd |
| alu_src_o | output | 1 | Second ALU operand is the immediate |
| mem_to_reg_o | output | 1 | Write-back from memory data |
| reg_write_o | output | 1 | Register file write enable |
| mem_read_o | output | 1 | Data memory read enable |
| mem_write_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch instruction |
| alu_op_o | output | 2 | Operation class passed to the ALU decoder |
| jump_o | output | 1 | Unconditional jump |
| link_o | output | 1 | Return address write to the link register |
| alu_ctl_o | output | 4 | ALU operation code |
| wr_reg_o | output | 5 | Resolved destination register number |
| wb_sel_o | output | 2 | Write-back source select |
| jump_target_o | output | 32 | Computed jump address |

## Verification
Jump-and-link is the one instruction that redirects the PC and writes a register in the same cycle. For this opcode, jump_target, wr_reg=31 and wb_sel=10 must all be correct together. The bench reaches this case in the exhaustive opcode/funct sweep. Each step of the sweep uses fresh random rt, rd, PC and index values, so a link select stuck on rt or rd, or a target built from the wrong bits, cannot match by chance. In each such step, the control word, the destination, the write-back select and the target are each judged against arithmetic expectations.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
   localparam logic [5:0] OPC_RTYPE = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_JMP   = 6'b000010;
   localparam logic [5:0] OPC_JAL   = 6'b000011;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   localparam logic [3:0] ALU_AND = 4'b0000;
   localparam logic [3:0] ALU_OR  = 4'b0001;
   localparam logic [3:0] ALU_ADD = 4'b0010;
   localparam logic [3:0] ALU_SUB = 4'b0110;
   localparam logic [3:0] ALU_SLT = 4'b0111;

   localparam logic [1:0] AOP_MEM = 2'b00;
   localparam logic [1:0] AOP_BR  = 2'b01;
   localparam logic [1:0] AOP_REG = 2'b10;

   localparam logic [1:0] WB_ALU  = 2'b00;
   localparam logic [1:0] WB_MEM  = 2'b01;
   localparam logic [1:0] WB_LINK = 2'b10;

   typedef struct packed {
      logic       reg_dst;
      logic       alu_src;
      logic       mem_to_reg;
      logic       reg_write;
      logic       mem_read;
      logic       mem_write;
      logic       branch;
      logic [1:0] alu_op;
      logic       jump;
      logic       link;
   } ctl_t;

   localparam ctl_t CTL_NONE = '0;

   function automatic logic funct_known(input logic [5:0] fn);
      return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
             (fn == FN_OR)  || (fn == FN_SLT);
   endfunction
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
   import ctl_pkg::*;
#(
   parameter int OP_W = 6
) (
   input  logic [OP_W-1:0] op_i,
   output ctl_t            ctl_o
);
   generate
      if (OP_W != 6) begin : g_bad_op_w
         $error("ctl_main_dec: opcode field must be 6 bits");
      end
   endgenerate

   always_comb begin
      ctl_o = CTL_NONE;
      unique case (op_i)
         OPC_RTYPE: begin
            ctl_o.reg_dst   = 1'b1;
            ctl_o.reg_write = 1'b1;
            ctl_o.alu_op    = AOP_REG;
         end
         OPC_LOAD: begin
            ctl_o.alu_src    = 1'b1;
            ctl_o.mem_to_reg = 1'b1;
            ctl_o.reg_write  = 1'b1;
            ctl_o.mem_read   = 1'b1;
            ctl_o.alu_op     = AOP_MEM;
         end
         OPC_STORE: begin
            ctl_o.alu_src   = 1'b1;
            ctl_o.mem_write = 1'b1;
            ctl_o.alu_op    = AOP_MEM;
         end
         OPC_BEQ: begin
            ctl_o.branch = 1'b1;
            ctl_o.alu_op = AOP_BR;
         end
         OPC_JMP: begin
            ctl_o.jump = 1'b1;
         end
         OPC_JAL: begin
            ctl_o.reg_write = 1'b1;
            ctl_o.jump      = 1'b1;
            ctl_o.link      = 1'b1;
         end
         default: ctl_o = CTL_NONE;
      endcase
   end

   always_comb begin
      if (!$isunknown(ctl_o)) begin
         AST_NO_DUAL_WRITE: assert (!(ctl_o.reg_write && ctl_o.mem_write))
            else $error("register and memory write together"); // R3
         AST_LINK_WITH_JUMP: assert (!ctl_o.link || (ctl_o.jump && ctl_o.reg_write))
            else $error("link without jump and write"); // R6
         AST_LOAD_TO_REG: assert (!ctl_o.mem_read || (ctl_o.mem_to_reg && ctl_o.reg_write))
            else $error("memory read not routed to register"); // R2
      end
   end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
   import ctl_pkg::*;
#(
   parameter int FUNCT_W = 6,
   parameter int CTL_W   = 4
) (
   input  logic [1:0]         alu_op_i,
   input  logic [FUNCT_W-1:0] funct_i,
   output logic [CTL_W-1:0]   alu_ctl_o
);
   generate
      if (FUNCT_W != 6 || CTL_W != 4) begin : g_bad_w
         $error("ctl_alu_dec: funct must be 6 bits and code 4 bits");
      end
   endgenerate

   always_comb begin
      alu_ctl_o = ALU_ADD;
      if (alu_op_i == AOP_BR) begin
         alu_ctl_o = ALU_SUB;
      end else if (alu_op_i == AOP_REG) begin
         unique case (funct_i)
            FN_ADD:  alu_ctl_o = ALU_ADD;
            FN_SUB:  alu_ctl_o = ALU_SUB;
            FN_AND:  alu_ctl_o = ALU_AND;
            FN_OR:   alu_ctl_o = ALU_OR;
            FN_SLT:  alu_ctl_o = ALU_SLT;
            default: alu_ctl_o = ALU_ADD;
         endcase
      end
   end

   always_comb begin
      if (!$isunknown({alu_op_i, alu_ctl_o})) begin
         AST_MEM_CLASS_ADDS: assert (alu_op_i != AOP_MEM || alu_ctl_o == ALU_ADD)
            else $error("memory class not add"); // R7
         AST_BR_CLASS_SUBS: assert (alu_op_i != AOP_BR || alu_ctl_o == ALU_SUB)
            else $error("branch class not subtract"); // R7
      end
   end
endmodule

// File: rtl/ctl_link_sel.sv
module ctl_link_sel
   import ctl_pkg::*;
#(
   parameter int REG_W    = 5,
   parameter int LINK_REG = 31
) (
   input  logic             reg_dst_i,
   input  logic             mem_to_reg_i,
   input  logic             link_i,
   input  logic [REG_W-1:0] rt_i,
   input  logic [REG_W-1:0] rd_i,
   output logic [REG_W-1:0] wr_reg_o,
   output logic [1:0]       wb_sel_o
);
   localparam logic [REG_W-1:0] LINK_NUM = REG_W'(LINK_REG);

   generate
      if (LINK_REG < 0 || LINK_REG >= (1 << REG_W)) begin : g_bad_link
         $error("ctl_link_sel: link register outside register space");
      end
   endgenerate

   always_comb begin
      if (link_i)         wr_reg_o = LINK_NUM;
      else if (reg_dst_i) wr_reg_o = rd_i;
      else                wr_reg_o = rt_i;

      if (link_i)            wb_sel_o = WB_LINK;
      else if (mem_to_reg_i) wb_sel_o = WB_MEM;
      else                   wb_sel_o = WB_ALU;
   end

   always_comb begin
      if (!$isunknown({link_i, wr_reg_o, wb_sel_o})) begin
         AST_LINK_DEST: assert (!link_i || (wr_reg_o == LINK_NUM && wb_sel_o == WB_LINK))
            else $error("link selects wrong"); // R9
         AST_WB_CODE_LEGAL: assert (wb_sel_o != 2'b11)
            else $error("illegal write-back code"); // R10
      end
   end
endmodule

// File: rtl/ctl_jump_tgt.sv
module ctl_jump_tgt #(
   parameter int PC_W  = 32,
   parameter int IDX_W = 26
) (
   input  logic [PC_W-1:0]  pc_plus4_i,
   input  logic [IDX_W-1:0] index_i,
   output logic [PC_W-1:0]  target_o
);
   localparam int LOW_W = IDX_W + 2;

   generate
      if (LOW_W > PC_W) begin : g_bad_w
         $error("ctl_jump_tgt: index wider than the address");
      end else if (LOW_W == PC_W) begin : g_full
         assign target_o = {index_i, 2'b00};
      end else begin : g_region
         assign target_o = {pc_plus4_i[PC_W-1:LOW_W], index_i, 2'b00};
      end
   endgenerate

   always_comb begin
      if (!$isunknown(target_o)) begin
         AST_TGT_ALIGNED: assert (target_o[1:0] == 2'b00)
            else $error("jump target not word aligned"); // R11
      end
   end
endmodule

// File: rtl/instr_ctl_decoder.sv
module instr_ctl_decoder
   import ctl_pkg::*;
#(
   parameter int OP_W     = 6,
   parameter int FUNCT_W  = 6,
   parameter int REG_W    = 5,
   parameter int PC_W     = 32,
   parameter int IDX_W    = 26,
   parameter int ALU_W    = 4,
   parameter int LINK_REG = 31
) (
   input  logic [OP_W-1:0]    op_i,
   input  logic [FUNCT_W-1:0] funct_i,
   input  logic [REG_W-1:0]   rt_i,
   input  logic [REG_W-1:0]   rd_i,
   input  logic [PC_W-1:0]    pc_plus4_i,
   input  logic [IDX_W-1:0]   instr_index_i,
   output logic               reg_dst_o,
   output logic               alu_src_o,
   output logic               mem_to_reg_o,
   output logic               reg_write_o,
   output logic               mem_read_o,
   output logic               mem_write_o,
   output logic               branch_o,
   output logic [1:0]         alu_op_o,
   output logic               jump_o,
   output logic               link_o,
   output logic [ALU_W-1:0]   alu_ctl_o,
   output logic [REG_W-1:0]   wr_reg_o,
   output logic [1:0]         wb_sel_o,
   output logic [PC_W-1:0]    jump_target_o
);
   ctl_t raw_ctl;
   ctl_t ctl;
   logic bad_funct;

   ctl_main_dec #(.OP_W(OP_W)) i_main (
      .op_i  (op_i),
      .ctl_o (raw_ctl)
   );

   assign bad_funct = (raw_ctl.alu_op == AOP_REG) && !funct_known(funct_i);
   assign ctl       = bad_funct ? CTL_NONE : raw_ctl;

   ctl_alu_dec #(.FUNCT_W(FUNCT_W), .CTL_W(ALU_W)) i_alu (
      .alu_op_i  (ctl.alu_op),
      .funct_i   (funct_i),
      .alu_ctl_o (alu_ctl_o)
   );

   ctl_link_sel #(.REG_W(REG_W), .LINK_REG(LINK_REG)) i_sel (
      .reg_dst_i    (ctl.reg_dst),
      .mem_to_reg_i (ctl.mem_to_reg),
      .link_i       (ctl.link),
      .rt_i         (rt_i),
      .rd_i         (rd_i),
      .wr_reg_o     (wr_reg_o),
      .wb_sel_o     (wb_sel_o)
   );

   ctl_jump_tgt #(.PC_W(PC_W), .IDX_W(IDX_W)) i_tgt (
      .pc_plus4_i (pc_plus4_i),
      .index_i    (instr_index_i),
      .target_o   (jump_target_o)
   );

   assign reg_dst_o    = ctl.reg_dst;
   assign alu_src_o    = ctl.alu_src;
   assign mem_to_reg_o = ctl.mem_to_reg;
   assign reg_write_o  = ctl.reg_write;
   assign mem_read_o   = ctl.mem_read;
   assign mem_write_o  = ctl.mem_write;
   assign branch_o     = ctl.branch;
   assign alu_op_o     = ctl.alu_op;
   assign jump_o       = ctl.jump;
   assign link_o       = ctl.link;

   always_comb begin
      if (!$isunknown({op_i, funct_i, reg_write_o, mem_write_o, branch_o, jump_o})) begin
         AST_BAD_FUNCT_INERT: assert (!(op_i == OPC_RTYPE && !funct_known(funct_i)) ||
                                      !(reg_write_o || mem_write_o || branch_o || jump_o))
            else $error("unknown funct changes state"); // R12
      end
   end
endmodule

// File: tb/test_instr_ctl_decoder.sv
module test_instr_ctl_decoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  op = '0;
   logic [5:0]  fn = '0;
   logic [4:0]  rt = '0;
   logic [4:0]  rd = '0;
   logic [31:0] pc4 = '0;
   logic [25:0] idx = '0;
   logic        reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump, link;
   logic [1:0]  alu_op, wb_sel;
   logic [3:0]  alu_ctl;
   logic [4:0]  wr_reg;
   logic [31:0] tgt;
   int          n_checks = 0;
   int          n_errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   instr_ctl_decoder i_instr_ctl_decoder (
      .op_i(op), .funct_i(fn), .rt_i(rt), .rd_i(rd), .pc_plus4_i(pc4),
      .instr_index_i(idx), .reg_dst_o(reg_dst), .alu_src_o(alu_src),
      .mem_to_reg_o(mem_to_reg), .reg_write_o(reg_write), .mem_read_o(mem_read),
      .mem_write_o(mem_write), .branch_o(branch), .alu_op_o(alu_op), .jump_o(jump),
      .link_o(link), .alu_ctl_o(alu_ctl), .wr_reg_o(wr_reg), .wb_sel_o(wb_sel),
      .jump_target_o(tgt)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s op=%b fn=%b actual=%h expected=%h", tag, op, fn, act, exp);
      end
   endtask

   // control word order: reg_dst alu_src mem_to_reg reg_write mem_read mem_write branch alu_op(2) jump link
   task automatic sweep_one();
      logic [10:0] exp_ctl;
      logic [3:0]  exp_alu;
      logic [4:0]  exp_wr;
      logic [1:0]  exp_wb;
      string       tag;
      bit          fn_ok;
      fn_ok = (fn == 6'd32) || (fn == 6'd34) || (fn == 6'd36) || (fn == 6'd37) || (fn == 6'd42);
      exp_ctl = '0;
      tag = "R12";
      if (op == 6'd0 && fn_ok) begin exp_ctl = 11'b1001000_10_00; tag = "R1"; end
      else if (op == 6'd35)    begin exp_ctl = 11'b0111100_00_00; tag = "R2"; end
      else if (op == 6'd43)    begin exp_ctl = 11'b0100010_00_00; tag = "R3"; end
      else if (op == 6'd4)     begin exp_ctl = 11'b0000001_01_00; tag = "R4"; end
      else if (op == 6'd2)     begin exp_ctl = 11'b0000000_00_10; tag = "R5"; end
      else if (op == 6'd3)     begin exp_ctl = 11'b0001000_00_11; tag = "R6"; end
      check(tag, 32'({reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write,
                      branch, alu_op, jump, link}), 32'(exp_ctl));
      // ALU code: 00 -> add, 01 -> subtract, 10 -> by funct
      case (exp_ctl[3:2])
         2'b01:   exp_alu = 4'b0110;
         2'b10:   case (fn)
                     6'd32: exp_alu = 4'b0010;
                     6'd34: exp_alu = 4'b0110;
                     6'd36: exp_alu = 4'b0000;
                     6'd37: exp_alu = 4'b0001;
                     default: exp_alu = 4'b0111;
                  endcase
         default: exp_alu = 4'b0010;
      endcase
      check(exp_ctl[3:2] == 2'b10 ? "R8" : "R7", 32'(alu_ctl), 32'(exp_alu));
      exp_wr = exp_ctl[0] ? 5'd31 : (exp_ctl[10] ? rd : rt);
      check("R9", 32'(wr_reg), 32'(exp_wr));
      exp_wb = exp_ctl[0] ? 2'b10 : (exp_ctl[8] ? 2'b01 : 2'b00);
      check("R10", 32'(wb_sel), 32'(exp_wb));
      check("R11", tgt, (pc4 & 32'hF000_0000) + (32'(idx) * 4));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // initial state: all-zero fields decode as R-format with unknown funct -> inert (R12)
      @(negedge clk); #1;
      check("R12", 32'({reg_write, mem_write, branch, jump}), 32'd0);
      for (int o = 0; o < 64; o++) begin
         for (int f = 0; f < 64; f++) begin
            @(negedge clk);
            op  = 6'(o);
            fn  = 6'(f);
            rt  = 5'($urandom);
            rd  = 5'($urandom);
            pc4 = $urandom;
            idx = 26'($urandom);
            #1;
            sweep_one();
         end
      end
      // JAL corner: index all ones and top PC nibble all ones (R6, R11)
      @(negedge clk);
      op = 6'd3; fn = 6'd0; pc4 = 32'hFFFF_FFFC; idx = '1; rt = 5'd1; rd = 5'd2;
      #1;
      check("R11", tgt, 32'hFFFF_FFFC);
      check("R6", 32'({reg_write, jump, link}), 32'h7);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule